// File: doc/BRIEF.md
# Segment Line Latch and Drive-Level Encoder

This block sits behind the capture logic of a dot-matrix segment driver. The capture logic assembles a full display line in a buffer. On a falling edge of the line strobe, this block copies the buffer into an output register, in straight or in mirrored channel order. For every output channel it then forms a two-bit code that names the analog drive level: first level, second level or middle level. The level shifter outside the block turns that code into a voltage.

The level code follows the data bit XORed with the frame-alternation phase, so the panel sees an AC drive. An active-low display-enable forces every channel to the middle level, and the reset state keeps that blank until the enable has been seen high. A reduced-width mode keeps only a central window of channels live and parks the others at the not-selected level. By default the phase input acts on the outputs at once. A parameter moves the phase sample to the line strobe instead.

Top module: `seg_line_driver`

## Requirements
- R1: `line_q` is loaded from `line_in` only in the clock cycle in which `line_clk`, sampled by `clk`, goes from 1 to 0. A rising edge or a steady level of `line_clk` leaves the data-driven part of every channel code unchanged.
- R2: Each channel n (0-based) drives `lvl_o[2n+1:2n]`. The codes are 2'b00 for the first level, 2'b01 for the second level and 2'b10 for the middle level. The code 2'b11 never appears.
- R3: While the display is enabled and the channel is active, the code is 2'b01 when the latched bit XOR the phase is 1, and 2'b00 otherwise. A latched 1 is the selected (ON) value and a latched 0 is the not-selected (OFF) value.
- R4: While `disp_en` is 0, every channel reads 2'b10 in the same cycle. This holds whatever the data, phase, mode and mirror inputs are, and the latch still loads on strobe falls during this time.
- R5: With `mode_full` at 0, only channels 40 to 279 (0-based) follow the latched data. All other channels give the not-selected code for the current phase: 2'b00 when the phase is 0 and 2'b01 when it is 1. This takes effect without waiting for a strobe.
- R6: With `mirror` at 0 at the strobe fall, bit i of `line_in` goes to channel i. With `mirror` at 1, bit i goes to channel NCH-1-i. The mirror setting acts only at the strobe fall.
- R7: With M_AT_LATCH=0, a change of `m_in` shows in the codes in the same cycle. With M_AT_LATCH=1, the phase used is the value of `m_in` sampled at the last strobe fall.
- R8: `rst_n` low clears the latch to all zeros at once and blanks every channel to 2'b10. After reset is released, the blank stays in force until the first `clk` edge at which `disp_en` is 1. Reset is released in step with `clk` through two flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_clk | input | 1 | Line strobe; its falling edge loads the line |
| line_in | input | NCH | Captured line from the capture logic, bit i = data i |
| m_in | input | 1 | Frame-alternation phase |
| disp_en | input | 1 | Active-low display-off (0 blanks all channels to middle level) |
| mode_full | input | 1 | 1: all channels live; 0: central window only |
| mirror | input | 1 | 1: mirrored channel order at the strobe fall |
| lvl_o | output | 2*NCH | Level code per channel, two bits each |

## Verification
An internal fault can corrupt the latch, the blank flag, the strobe edge detector or the phase path. Each of these shows up at `lvl_o` within one clock cycle. A lost or extra strobe-fall detection leaves stale data or loads data too early, and the very next sample of the codes shows it. A wrong mirror index or window bound hits only particular channels, so the bench compares every channel against a model computed from the requirements after each step. A blank flag stuck high, or one that clears too early, shows at once as the middle level everywhere or its absence just after reset.

// File: rtl/seg_lvl_pkg.sv
package seg_lvl_pkg;

  typedef enum logic [1:0] {
    LVL_V0 = 2'b00,
    LVL_V1 = 2'b01,
    LVL_VM = 2'b10
  } lvl_t;

  function automatic lvl_t lvl_encode(input logic bit_on, input logic phase,
                                      input logic blank);
    lvl_t r;
    if (blank)                r = LVL_VM;
    else if (bit_on ^ phase)  r = LVL_V1;
    else                      r = LVL_V0;
    return r;
  endfunction

endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/seg_strobe_fall.sv
module seg_strobe_fall (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic fall
);
  logic strobe_q;
  logic strobe_d;

  always_comb strobe_d = strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe_d;
  end

  assign fall = strobe_q & ~strobe;
endmodule

// File: rtl/seg_line_reg.sv
module seg_line_reg #(
  parameter int NCH        = 320,
  parameter bit M_AT_LATCH = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           mirror,
  input  logic [NCH-1:0] line_in,
  input  logic           m_in,
  input  logic           disp_en,
  output logic [NCH-1:0] line_q,
  output logic           m_eff,
  output logic           blank_q
);
  logic [NCH-1:0] ordered;
  logic [NCH-1:0] line_d;
  logic           blank_d;

  for (genvar g = 0; g < NCH; g++) begin : g_order
    assign ordered[g] = mirror ? line_in[NCH-1-g] : line_in[g];
  end

  always_comb begin
    line_d = line_q;
    if (load) line_d = ordered;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_d;
  end

  always_comb blank_d = blank_q & ~disp_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blank_q <= 1'b1;
    else        blank_q <= blank_d;
  end

  if (M_AT_LATCH) begin : g_m_reg
    logic m_q;
    logic m_d;
    always_comb begin
      m_d = m_q;
      if (load) m_d = m_in;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) m_q <= 1'b0;
      else        m_q <= m_d;
    end
    assign m_eff = m_q;
  end else begin : g_m_comb
    assign m_eff = m_in;
  end
endmodule

// File: rtl/seg_lvl_enc.sv
module seg_lvl_enc
  import seg_lvl_pkg::*;
#(
  parameter int NCH    = 320,
  parameter int WIN_LO = 40,
  parameter int WIN_HI = 279
) (
  input  logic [NCH-1:0]   line_q,
  input  logic             m_eff,
  input  logic             blank,
  input  logic             mode_full,
  output logic [2*NCH-1:0] lvl_o
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam bit InWin = (g >= WIN_LO) && (g <= WIN_HI);
    logic live;
    lvl_t code;
    assign live = mode_full | InWin;
    always_comb code = lvl_encode(line_q[g] & live, m_eff, blank);
    assign lvl_o[2*g +: 2] = code;
  end
endmodule

// File: rtl/seg_line_driver.sv
module seg_line_driver #(
  parameter int NCH        = 320,
  parameter int WIN_LO     = 40,
  parameter int WIN_HI     = 279,
  parameter bit M_AT_LATCH = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_clk,
  input  logic [NCH-1:0]   line_in,
  input  logic             m_in,
  input  logic             disp_en,
  input  logic             mode_full,
  input  logic             mirror,
  output logic [2*NCH-1:0] lvl_o
);
  logic           rst_sync_n;
  logic           line_fall;
  logic [NCH-1:0] line_q;
  logic           m_eff;
  logic           blank_q;
  logic           blank_all;

  seg_rst_sync i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  seg_strobe_fall i_fall (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .strobe (line_clk),
    .fall   (line_fall)
  );

  seg_line_reg #(.NCH(NCH), .M_AT_LATCH(M_AT_LATCH)) i_line (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (line_fall),
    .mirror  (mirror),
    .line_in (line_in),
    .m_in    (m_in),
    .disp_en (disp_en),
    .line_q  (line_q),
    .m_eff   (m_eff),
    .blank_q (blank_q)
  );

  assign blank_all = blank_q | ~disp_en;

  seg_lvl_enc #(.NCH(NCH), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) i_enc (
    .line_q    (line_q),
    .m_eff     (m_eff),
    .blank     (blank_all),
    .mode_full (mode_full),
    .lvl_o     (lvl_o)
  );
endmodule

// File: rtl/seg_line_driver_chk.sv
module seg_line_driver_chk #(
  parameter int NCH = 320
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_fall,
  input logic [NCH-1:0]   line_q,
  input logic [NCH-1:0]   line_in,
  input logic             mirror,
  input logic             disp_en,
  input logic             blank_q,
  input logic             mode_full,
  input logic             m_eff,
  input logic [2*NCH-1:0] lvl_o
);
  logic any11;
  logic [NCH-1:0] line_rev;

  always_comb begin
    any11 = 1'b0;
    for (int i = 0; i < NCH; i++) any11 |= &lvl_o[2*i +: 2];
  end

  always_comb line_rev = {<<{line_in}};

  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !line_fall |=> $stable(line_q));

  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    line_fall |=> line_q == ($past(mirror) ? $past(line_rev) : $past(line_in)));

  a_r2_no_code11: assert property (@(posedge clk) disable iff (!rst_n)
    !any11);

  a_r4_off_mid: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |-> lvl_o == {NCH{2'b10}});

  a_r8_blank_mid: assert property (@(posedge clk) disable iff (!rst_n)
    blank_q |-> lvl_o == {NCH{2'b10}});

  a_r5_outer_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && !blank_q && !mode_full) |->
      (lvl_o[1:0] == {1'b0, m_eff}) && (lvl_o[2*NCH-1 -: 2] == {1'b0, m_eff}));
endmodule

bind seg_line_driver seg_line_driver_chk #(.NCH(NCH)) i_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .line_fall (line_fall),
  .line_q    (line_q),
  .line_in   (line_in),
  .mirror    (mirror),
  .disp_en   (disp_en),
  .blank_q   (blank_q),
  .mode_full (mode_full),
  .m_eff     (m_eff),
  .lvl_o     (lvl_o)
);

// File: tb/test_seg_line_driver.sv
module test_seg_line_driver;
  localparam int NCH = 320;
  localparam int WLO = 40;
  localparam int WHI = 279;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             line_clk;
  logic [NCH-1:0]   line_in;
  logic             m_in;
  logic             disp_en;
  logic             mode_full;
  logic             mirror;
  logic [2*NCH-1:0] lvl_o;
  logic [2*NCH-1:0] lvl_r;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [NCH-1:0] model;
  logic           blank_m;
  logic           m_lat;
  logic [31:0]    rng = 32'h1357_9bdf;

  always #2 clk = ~clk;

  seg_line_driver #(.NCH(NCH), .WIN_LO(WLO), .WIN_HI(WHI)) i_seg_line_driver (
    .clk(clk), .rst_n(rst_n), .line_clk(line_clk), .line_in(line_in),
    .m_in(m_in), .disp_en(disp_en), .mode_full(mode_full), .mirror(mirror),
    .lvl_o(lvl_o)
  );

  seg_line_driver #(.NCH(NCH), .WIN_LO(WLO), .WIN_HI(WHI), .M_AT_LATCH(1'b1))
    i_seg_line_driver_mreg (
    .clk(clk), .rst_n(rst_n), .line_clk(line_clk), .line_in(line_in),
    .m_in(m_in), .disp_en(disp_en), .mode_full(mode_full), .mirror(mirror),
    .lvl_o(lvl_r)
  );

  function automatic logic [1:0] exp_code(input int ch, input logic ph);
    logic live, d;
    if (blank_m || !disp_en) return 2'b10;
    live = mode_full || (ch >= WLO && ch <= WHI);
    d = live ? model[ch] : 1'b0;
    return (d ^ ph) ? 2'b01 : 2'b00;
  endfunction

  task automatic check_out(input string req, input logic [2*NCH-1:0] act,
                           input logic ph);
    int bad = -1;
    logic [1:0] e, eb, ab;
    eb = 2'b00; ab = 2'b00;
    for (int ch = 0; ch < NCH; ch++) begin
      e = exp_code(ch, ph);
      if (act[2*ch +: 2] !== e && bad < 0) begin
        bad = ch; eb = e; ab = act[2*ch +: 2];
      end
    end
    n_chk++;
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s ch%0d actual %b expected %b", req, bad, ab, eb);
    end
  endtask

  function automatic logic [NCH-1:0] mkpat();
    logic [NCH-1:0] p;
    for (int w = 0; w < NCH / 32; w++) begin
      rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
      p[32*w +: 32] = rng;
    end
    return p;
  endfunction

  task automatic do_latch(input logic [NCH-1:0] p);
    line_in = p;
    line_clk = 1'b1;
    @(negedge clk);
    line_clk = 1'b0;
    @(negedge clk);
    for (int ch = 0; ch < NCH; ch++) model[ch] = mirror ? p[NCH-1-ch] : p[ch];
    m_lat = m_in;
  endtask

  task automatic both(input string req);
    check_out(req, lvl_o, m_in);
    check_out({req, " R7 latched phase"}, lvl_r, m_lat);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; line_clk = 1'b0; line_in = '0; m_in = 1'b0;
    disp_en = 1'b0; mode_full = 1'b1; mirror = 1'b0;
    model = '0; blank_m = 1'b1; m_lat = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    both("R8 reset blank");
    disp_en = 1'b1; #1;
    both("R8 blank holds before clock");
    @(negedge clk); blank_m = 1'b0;
    both("R8 cleared latch gives first level");

    // R3 R6 R7 sweep over data, mirror and phase
    for (int p = 0; p < 8; p++) begin
      for (int mir = 0; mir < 2; mir++) begin
        logic [NCH-1:0] pat;
        pat = (p == 0) ? '0 : (p == 1) ? '1 : (p == 2) ? {NCH/2{2'b10}} : mkpat();
        mirror = mir[0];
        m_in = p[0];
        do_latch(pat);
        both("R3 R6 R2 after latch");
        for (int mv = 0; mv < 2; mv++) begin
          m_in = mv[0]; #1;
          both("R7 R3 phase change");
          @(negedge clk);
        end
      end
    end

    // R1: rising strobe and changed data do not load
    mirror = 1'b0;
    line_in = ~line_in; line_clk = 1'b1;
    @(negedge clk); @(negedge clk);
    both("R1 no load on rise");
    mirror = 1'b1; #1;
    both("R6 mirror change between strobes");
    mirror = 1'b0;
    line_clk = 1'b0;
    @(negedge clk);
    for (int ch = 0; ch < NCH; ch++) model[ch] = line_in[ch];
    m_lat = m_in;
    both("R1 load on fall");

    // R5 reduced mode
    do_latch('1);
    mode_full = 1'b0;
    for (int mv = 0; mv < 2; mv++) begin
      m_in = mv[0]; #1;
      both("R5 window ones");
      @(negedge clk);
    end
    do_latch(mkpat());
    both("R5 window pattern");
    mirror = 1'b1;
    do_latch(mkpat());
    both("R5 R6 window mirrored");
    mode_full = 1'b1; #1;
    both("R5 back to full");

    // R4 display off
    for (int k = 0; k < 4; k++) begin
      disp_en = 1'b0; m_in = k[0]; mode_full = k[1]; #1;
      both("R4 off");
      @(negedge clk);
    end
    mirror = 1'b0;
    do_latch(mkpat());
    both("R4 latch while off");
    disp_en = 1'b1; #1;
    both("R4 R1 data loaded during off");
    @(negedge clk);

    done = 1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end
endmodule